// File: doc/BRIEF.md
# Dual-Rate Scan Chain

This block is a parameterised chain of scan cells whose update rate depends on the test mode. In shift mode every cell takes the value of its upstream neighbour on both halves of each system clock period, so a chain of N cells is filled or emptied in N/2 system cycles. In functional mode each cell loads its own functional data bit once per system period, on the rising half. The design is single-edge and synthesizable: it runs on a clock at twice the system rate, and a phase input says whether the system clock is currently high or low. A rising-half update happens on a fast-clock edge where the phase goes from 0 to 1. A falling-half update happens on an edge where it goes from 1 to 0.

Alongside the serial path, each cell drives a registered, gated copy of its value toward the logic under test. That copy is frozen for as long as shift mode is in force, so the downstream logic sees no toggling while patterns stream through. It reloads only on fast-clock edges that carry no update while the chain is in functional mode. A typical test runs as follows: shift a pattern in with scan enable high, do one capture with scan enable low, then shift the response out with scan enable high.

Top module: `ddr_scan_chain`

## Requirements
- R1: While the latched mode is shift, every update moves scan_in into cell 0 and the value of cell i-1 into cell i, on both rising and falling updates.
- R2: While the mode is functional, updates occur only on rising edges, and each cell i loads func_d[i]. A falling edge leaves all cells unchanged.
- R3: A pattern of N bits is fully loaded after N fast-clock updates, which is N/2 system cycles. If the first bit shifted is pattern bit N-1 and the last is bit 0, cell i then holds pattern bit i.
- R4: On a fast-clock edge that carries no update, no cell changes. Each update moves data exactly one cell.
- R5: scan_out is the value of cell N-1, the cell farthest from scan_in.
- R6: While the latched mode is shift, core_q does not change.
- R7: core_q[i] loads the current value of cell i only on an edge with no update while the latched mode is functional. It therefore shows a capture one fast-clock edge after the capturing rising edge.
- R8: scan_en is sampled only at rising edges. A change of scan_en before a falling edge affects neither that falling edge nor core_q until the next rising edge.
- R9: A synchronous active-high rst clears all cells, core_q and the latched mode to 0.
- R10: A rising update needs phase=1 after phase=0 on consecutive fast-clock edges. A falling update needs phase=0 after phase=1. If phase holds its value, no update occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Fast clock at twice the system rate |
| rst | input | 1 | Synchronous active-high reset |
| phase | input | 1 | 1 while the system clock is high, 0 while low |
| scan_en | input | 1 | 1 selects shift mode, 0 selects functional capture |
| scan_in | input | 1 | Serial input into cell 0 |
| func_d | input | N | Functional data, bit i into cell i |
| scan_out | output | 1 | Serial output from cell N-1 |
| core_q | output | N | Gated cell values toward the logic under test |

## Verification
The bench sweeps several patterns: all zeros, all ones, alternating bits, and random values. It checks that each pattern appears at scan_out exactly N fast-clock updates after its first bit enters, in the original bit order. A design that shifted only on rising edges, or that let data ripple through several cells, would put the wrong bit on scan_out. The bench also drops scan_en just before a falling edge in shift mode, and raises it before a falling edge in functional mode. A design that sampled the mode on every edge would either stall the shift or corrupt the captured data. Finally, the bench holds phase steady across edges and watches core_q throughout each shift. Spurious updates, or outputs that leak during shifting, show up as mismatches against the reference model.

// File: rtl/ddr_scan_pkg.sv
package ddr_scan_pkg;

  typedef enum logic {
    MODE_FUNC  = 1'b0,
    MODE_SHIFT = 1'b1
  } cell_mode_e;

  // rising half begins: phase was low, is now high
  function automatic logic is_rise(input logic now_ph, input logic prev_ph);
    return now_ph & ~prev_ph;
  endfunction

  // falling half begins: phase was high, is now low
  function automatic logic is_fall(input logic now_ph, input logic prev_ph);
    return ~now_ph & prev_ph;
  endfunction

  // system cycles needed to stream n bits at two bits per cycle
  function automatic int unsigned load_cycles(input int unsigned n);
    return (n + 1) / 2;
  endfunction

endpackage

// File: rtl/ddr_edge_seq.sv
module ddr_edge_seq
  import ddr_scan_pkg::*;
(
  input  logic       clk2x,
  input  logic       rst,
  input  logic       phase,
  input  logic       scan_en,
  output logic       upd_pulse,
  output cell_mode_e upd_mode,
  output cell_mode_e mode_q
);

  logic phase_q;
  logic rise_tick;
  logic fall_tick;

  // phase_q tracks phase even in reset so no false edge appears after release
  always_ff @(posedge clk2x) begin
    phase_q <= phase;
  end

  assign rise_tick = is_rise(phase, phase_q);
  assign fall_tick = is_fall(phase, phase_q);

  always_ff @(posedge clk2x) begin
    if (rst) begin
      mode_q <= MODE_FUNC;
    end else if (rise_tick) begin
      mode_q <= scan_en ? MODE_SHIFT : MODE_FUNC;
    end
  end

  // on a rising edge the freshly sampled enable rules; on a falling edge the latched one
  assign upd_mode  = rise_tick ? (scan_en ? MODE_SHIFT : MODE_FUNC) : mode_q;
  assign upd_pulse = rise_tick | (fall_tick & (mode_q == MODE_SHIFT));

  assert_ticks_exclusive_R10 : assert property (@(posedge clk2x) disable iff (rst)
    !(rise_tick && fall_tick));

  assert_update_needs_phase_change_R10 : assert property (@(posedge clk2x) disable iff (rst)
    upd_pulse |-> (phase != $past(phase)));

  assert_mode_only_at_rise_R8 : assert property (@(posedge clk2x) disable iff (rst)
    !rise_tick |=> $stable(mode_q));

  assert_no_func_fall_update_R2 : assert property (@(posedge clk2x) disable iff (rst)
    (upd_pulse && upd_mode == MODE_FUNC) |-> (phase && !$past(phase)));

endmodule

// File: rtl/ddr_scan_cell.sv
module ddr_scan_cell
  import ddr_scan_pkg::*;
(
  input  logic       clk2x,
  input  logic       rst,
  input  logic       upd,
  input  cell_mode_e mode,
  input  logic       sin,
  input  logic       fdat,
  output logic       q
);

  always_ff @(posedge clk2x) begin
    if (rst) begin
      q <= 1'b0;
    end else if (upd) begin
      q <= (mode == MODE_SHIFT) ? sin : fdat;
    end
  end

  assert_shift_one_hop_R1 : assert property (@(posedge clk2x) disable iff (rst)
    (upd && mode == MODE_SHIFT) |=> (q == $past(sin)));

  assert_capture_func_R2 : assert property (@(posedge clk2x) disable iff (rst)
    (upd && mode == MODE_FUNC) |=> (q == $past(fdat)));

  assert_hold_between_R4 : assert property (@(posedge clk2x) disable iff (rst)
    !upd |=> $stable(q));

endmodule

// File: rtl/ddr_core_gate.sv
module ddr_core_gate
  import ddr_scan_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk2x,
  input  logic         rst,
  input  logic         upd,
  input  cell_mode_e   mode_q,
  input  logic [W-1:0] cell_val,
  output logic [W-1:0] core_q
);

  logic gate_open;

  // pass only when neither an update nor shift mode is in force
  assign gate_open = ~upd & (mode_q == MODE_FUNC);

  always_ff @(posedge clk2x) begin
    if (rst) begin
      core_q <= '0;
    end else if (gate_open) begin
      core_q <= cell_val;
    end
  end

  assert_frozen_in_shift_R6 : assert property (@(posedge clk2x) disable iff (rst)
    (mode_q == MODE_SHIFT) |=> $stable(core_q));

  assert_closed_on_pulse_R7 : assert property (@(posedge clk2x) disable iff (rst)
    upd |=> $stable(core_q));

endmodule

// File: rtl/ddr_scan_chain.sv
module ddr_scan_chain
  import ddr_scan_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic         clk2x,
  input  logic         rst,
  input  logic         phase,
  input  logic         scan_en,
  input  logic         scan_in,
  input  logic [N-1:0] func_d,
  output logic         scan_out,
  output logic [N-1:0] core_q
);

  localparam int unsigned LAST = N - 1;

  logic       upd_pulse;
  cell_mode_e upd_mode;
  cell_mode_e mode_q;
  logic [N-1:0] cell_q;

  ddr_edge_seq u_seq (
    .clk2x    (clk2x),
    .rst      (rst),
    .phase    (phase),
    .scan_en  (scan_en),
    .upd_pulse(upd_pulse),
    .upd_mode (upd_mode),
    .mode_q   (mode_q)
  );

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic sin_w;
    if (i == 0) begin : g_head
      assign sin_w = scan_in;
    end else begin : g_link
      assign sin_w = cell_q[i-1];
    end
    ddr_scan_cell u_cell (
      .clk2x(clk2x),
      .rst  (rst),
      .upd  (upd_pulse),
      .mode (upd_mode),
      .sin  (sin_w),
      .fdat (func_d[i]),
      .q    (cell_q[i])
    );
  end

  assign scan_out = cell_q[LAST];

  ddr_core_gate #(.W(N)) u_gate (
    .clk2x   (clk2x),
    .rst     (rst),
    .upd     (upd_pulse),
    .mode_q  (mode_q),
    .cell_val(cell_q),
    .core_q  (core_q)
  );

  assert_tail_holds_R4 : assert property (@(posedge clk2x) disable iff (rst)
    !upd_pulse |=> $stable(scan_out));

  assert_tail_takes_upstream_R5 : assert property (@(posedge clk2x) disable iff (rst)
    (upd_pulse && upd_mode == MODE_SHIFT) |=> (scan_out == $past(cell_q[LAST-1])));

endmodule

// File: tb/ddr_scan_chain_tb.sv
module ddr_scan_chain_tb_top;

  localparam int unsigned N = 8;

  logic         clk2x = 1'b0;
  logic         rst;
  logic         phase;
  logic         scan_en;
  logic         scan_in;
  logic [N-1:0] func_d;
  logic         scan_out;
  logic [N-1:0] core_q;

  int checks = 0;
  int fails  = 0;

  // reference state
  logic [N-1:0] m_cells;
  logic [N-1:0] m_core;
  logic         m_p;
  logic         m_mode;

  always #5 clk2x = ~clk2x;

  ddr_scan_chain #(.N(N)) dut_i (
    .clk2x   (clk2x),
    .rst     (rst),
    .phase   (phase),
    .scan_en (scan_en),
    .scan_in (scan_in),
    .func_d  (func_d),
    .scan_out(scan_out),
    .core_q  (core_q)
  );

  task automatic check(input logic ok, input string req,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; phase = 1'b0; scan_en = 1'b0; scan_in = 1'b0; func_d = '0;
    repeat (3) @(posedge clk2x);
    @(negedge clk2x);
    rst = 1'b0;
    m_cells = '0; m_core = '0; m_p = 1'b0; m_mode = 1'b0;
  endtask

  // one fast-clock edge; reference advanced from the requirements
  task automatic step(input logic p, input logic se, input logic si,
                      input logic [N-1:0] fd);
    logic rise, fall, upd, shf;
    logic [N-1:0] nc;
    phase = p; scan_en = se; scan_in = si; func_d = fd;
    @(posedge clk2x);
    @(negedge clk2x);
    rise = p && !m_p;
    fall = !p && m_p;
    upd  = rise || (fall && m_mode);
    shf  = rise ? se : m_mode;
    nc   = m_cells;
    if (upd) nc = shf ? {m_cells[N-2:0], si} : fd;
    if (!upd && !m_mode) m_core = m_cells;
    if (rise) m_mode = se;
    m_cells = nc;
    m_p = p;
    check(scan_out == m_cells[N-1], "R1 R5 scan_out vs model",
          {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, m_cells[N-1]});
    check(core_q == m_core, "R6 R7 core_q vs model", core_q, m_core);
  endtask

  task automatic run_pattern(input logic [N-1:0] a, input logic [N-1:0] b,
                             input logic [N-1:0] c, input logic [N-1:0] d);
    logic [N-1:0] frozen;
    logic [N-1:0] got;
    logic         so_before;
    // shift A in: N updates = N/2 system cycles
    frozen = core_q;
    for (int k = 0; k < N; k++) begin
      step((k % 2) == 0, 1'b1, a[N-1-k], d);
      check(core_q == frozen, "R6 core frozen during shift-in", core_q, frozen);
    end
    check(scan_out == a[N-1], "R3 first bit at tail after N/2 cycles",
          {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, a[N-1]});
    // stream A out while shifting B in
    got = '0;
    for (int k = 0; k < N; k++) begin
      got[N-1-k] = scan_out;
      step((k % 2) == 0, 1'b1, b[N-1-k], d);
      check(core_q == frozen, "R6 core frozen during shift-out", core_q, frozen);
    end
    check(got == a, "R3 R5 unloaded pattern order", got, a);
    // capture C on rising edge, then falling edge with other data
    step(1'b1, 1'b0, 1'b0, c);
    step(1'b0, 1'b0, 1'b0, d);
    check(core_q == c, "R2 R7 capture then fall ignored", core_q, c);
    // functional rise with c again, enable raised before the fall
    step(1'b1, 1'b0, 1'b0, c);
    so_before = scan_out;
    step(1'b0, 1'b1, 1'b1, d);
    check(core_q == c && scan_out == so_before, "R8 enable before fall ignored",
          core_q, c);
    // shift C out; enable dropped before each fall must not stop shifting
    frozen = core_q;
    got = '0;
    for (int k = 0; k < N; k++) begin
      got[N-1-k] = scan_out;
      step((k % 2) == 0, (k % 2) == 0, 1'b0, d);
      check(core_q == frozen, "R6 R8 core frozen, shift keeps going", core_q, frozen);
    end
    check(got == c, "R1 R8 captured pattern unloaded", got, c);
    // phase held low, then held high: no updates
    so_before = scan_out;
    step(1'b0, 1'b1, 1'b1, d);
    check(scan_out == so_before, "R10 no update with phase held low",
          {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, so_before});
    step(1'b1, 1'b1, 1'b1, d);
    so_before = scan_out;
    step(1'b1, 1'b1, 1'b0, d);
    check(scan_out == so_before, "R4 R10 no update with phase held high",
          {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, so_before});
    step(1'b0, 1'b1, 1'b0, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk2x);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] pats [6];
    do_reset();
    check(core_q == '0, "R9 core_q after reset", core_q, '0);
    check(scan_out == 1'b0, "R9 scan_out after reset",
          {{(N-1){1'b0}}, scan_out}, '0);
    pats[0] = '0;
    pats[1] = '1;
    for (int i = 0; i < N; i++) pats[2][i] = i[0];
    for (int i = 3; i < 6; i++) pats[i] = N'($urandom);
    for (int i = 0; i < 6; i++) begin
      run_pattern(pats[i], pats[(i + 1) % 6], pats[(i + 2) % 6], ~pats[i]);
    end
    // functional mode over several system cycles: only rising captures
    for (int k = 0; k < 8; k++) begin
      step((k % 2) == 0, 1'b0, 1'b0, N'($urandom));
    end
    check(m_mode == 1'b0, "R2 stayed functional", '0, '0);
    // mid-run reset
    step(1'b1, 1'b0, 1'b0, '1);
    step(1'b0, 1'b0, 1'b0, '1);
    do_reset();
    check(core_q == '0 && scan_out == 1'b0, "R9 cleared mid-run", core_q, '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule